// File: doc/BRIEF.md
# Write Status Polling Responder

This block is the read-return path of a byte-wide nonvolatile memory with a self-timed programming cycle. When the memory is idle, a read returns the array word. While the write controller reports that programming is in progress, a read of the byte just written returns a status word instead. The top bit of that word is the inverse of the written top bit. The next bit changes level after every completed read access. The remaining low bits repeat the written data unchanged. Host software can poll either bit to find out when programming has ended, and must still wait about 10 µs after polling shows completion before it starts another write.

All bus controls are active low and are sampled on the block clock. A read access is the state where chip select and output enable are both low. A write access is the state where chip select and write strobe are low with output enable high. The block keeps the address and data of the most recent write access, and it keeps a toggle register. Outputs are registered, so they follow the sampled bus by one clock.

Top module: `poll_status_resp`

## Requirements
- R1: When `ce_n` or `oe_n` was high at a clock edge, after that edge `rd_oe` is 0 and `rd_data` is all zeros. This also holds during reset.
- R2: When `busy` is 0, a read access (`ce_n`=0, `oe_n`=0) returns `arr_rdata` with `rd_oe`=1 one clock later.
- R3: When `busy` is 1 and a read access targets the captured write address, `rd_data[7]` equals the inverse of captured data bit 7.
- R4: During a status read, `rd_data[6]` shows the toggle register. The toggle register inverts once when a read access ends while `busy` stays high. It does not change while a read access is held.
- R5: During a status read, `rd_data[5:0]` equal the captured data bits 5 to 0.
- R6: The toggle register is cleared by reset and by a rising edge of `busy`. A clear takes priority over a toggle in the same cycle.
- R7: While `busy` is 0, the toggle register holds, and reads of the captured address return true array data.
- R8: The captured address and data take the values present during the most recent write access made while `busy` is 0. Write accesses made while `busy` is 1 leave them unchanged.
- R9: With the default `MATCH_ADDR`=1, a read during `busy` at any address other than the captured one returns `arr_rdata`.
- R10: A cycle with `ce_n`, `oe_n` and `we_n` all low is a read access and captures nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Access address |
| din | input | DATA_W | Host write data |
| busy | input | 1 | Programming cycle in progress, from the write controller |
| arr_rdata | input | DATA_W | Array read data for `addr` |
| rd_data | output | DATA_W | Registered read return |
| rd_oe | output | 1 | Registered drive enable for the tri-state data bus |

## Verification
The bench holds a read access low for two cycles to catch a toggle that advances every clock instead of once per access. A wrong design there would repeat one polling value or alternate it too fast. It raises `busy` again right after reads that left the toggle set, and it pulses reset while the toggle is set. A design that forgets either clear would start the next poll on the wrong level. It issues a write while busy and a write-like cycle with output enable low. A design that captured either one would report polling against the wrong byte. It also reads an unrelated address during busy, and reads the captured address after busy falls, to catch a responder that returns status where array data is due.

// File: rtl/psr_pkg.sv
package psr_pkg;

   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_e;

   // Output enable low always wins: it makes a read and blocks any write.
   function automatic acc_e decode_access(input logic ce_n, input logic oe_n, input logic we_n);
      if (ce_n)  return ACC_IDLE;
      if (!oe_n) return ACC_READ;
      if (!we_n) return ACC_WRITE;
      return ACC_IDLE;
   endfunction

endpackage

// File: rtl/psr_access_det.sv
module psr_access_det
   import psr_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic oe_n,
   input  logic we_n,
   input  logic busy,
   output logic rd_act,
   output logic wr_act,
   output logic rd_end,
   output logic busy_rise
);
   acc_e acc;
   logic rd_q;
   logic busy_q;

   always_comb begin
      acc    = decode_access(ce_n, oe_n, we_n);
      rd_act = (acc == ACC_READ);
      wr_act = (acc == ACC_WRITE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q   <= 1'b0;
         busy_q <= 1'b0;
      end else begin
         rd_q   <= rd_act;
         busy_q <= busy;
      end
   end

   assign rd_end    = rd_q && !rd_act;
   assign busy_rise = busy && !busy_q;

endmodule

// File: rtl/psr_last_byte.sv
module psr_last_byte #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [ADDR_W-1:0] last_addr,
   output logic [DATA_W-1:0] last_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_addr <= '0;
         last_data <= '0;
      end else if (cap_en) begin
         last_addr <= addr;
         last_data <= din;
      end
   end
endmodule

// File: rtl/psr_toggle.sv
module psr_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic advance,
   output logic tog
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tog <= 1'b0;
      else if (clear)   tog <= 1'b0;
      else if (advance) tog <= ~tog;
   end
endmodule

// File: rtl/psr_read_mux.sv
module psr_read_mux #(
   parameter int ADDR_W     = 15,
   parameter int DATA_W     = 8,
   parameter bit MATCH_ADDR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_act,
   input  logic              busy,
   input  logic              tog,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] last_addr,
   input  logic [DATA_W-1:0] last_data,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_oe
);
   localparam int POLL_POS = DATA_W - 1;
   localparam int TOG_POS  = DATA_W - 2;

   logic              hit;
   logic [DATA_W-1:0] status;
   logic [DATA_W-1:0] nxt;

   generate
      if (MATCH_ADDR) begin : g_match
         assign hit = (addr == last_addr);
      end else begin : g_any
         logic unused_addr;
         assign unused_addr = ^{addr, last_addr};
         assign hit = 1'b1;
      end
   endgenerate

   always_comb begin
      status           = last_data;
      status[POLL_POS] = ~last_data[POLL_POS];
      status[TOG_POS]  = tog;
      nxt              = (busy && hit) ? status : arr_rdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
         rd_oe   <= 1'b0;
      end else begin
         rd_oe   <= rd_act;
         rd_data <= rd_act ? nxt : '0;
      end
   end
endmodule

// File: rtl/poll_status_resp.sv
module poll_status_resp #(
   parameter int ADDR_W     = 15,
   parameter int DATA_W     = 8,
   parameter bit MATCH_ADDR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   input  logic              busy,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_oe
);
   generate
      if (DATA_W < 3) begin : g_bad_data_w
         $error("poll_status_resp: DATA_W must be at least 3");
      end
      if (ADDR_W < 1) begin : g_bad_addr_w
         $error("poll_status_resp: ADDR_W must be at least 1");
      end
   endgenerate

   logic              rd_act;
   logic              wr_act;
   logic              rd_end;
   logic              busy_rise;
   logic              tog_q;
   logic [ADDR_W-1:0] last_addr;
   logic [DATA_W-1:0] last_data;

   psr_access_det u_det (
      .clk      (clk),
      .rst_n    (rst_n),
      .ce_n     (ce_n),
      .oe_n     (oe_n),
      .we_n     (we_n),
      .busy     (busy),
      .rd_act   (rd_act),
      .wr_act   (wr_act),
      .rd_end   (rd_end),
      .busy_rise(busy_rise)
   );

   psr_last_byte #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_last (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (wr_act && !busy),
      .addr     (addr),
      .din      (din),
      .last_addr(last_addr),
      .last_data(last_data)
   );

   psr_toggle u_tog (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (busy_rise),
      .advance(rd_end && busy),
      .tog    (tog_q)
   );

   psr_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MATCH_ADDR(MATCH_ADDR)) u_mux (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_act   (rd_act),
      .busy     (busy),
      .tog      (tog_q),
      .addr     (addr),
      .last_addr(last_addr),
      .last_data(last_data),
      .arr_rdata(arr_rdata),
      .rd_data  (rd_data),
      .rd_oe    (rd_oe)
   );

endmodule

// File: rtl/psr_chk.sv
module psr_chk #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              busy,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_oe,
   input logic              tog,
   input logic [ADDR_W-1:0] last_addr,
   input logic [DATA_W-1:0] last_data
);
   // R1
   bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || oe_n) |=> (!rd_oe && rd_data == '0));

   // R2
   read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n) |=> rd_oe);

   // R3
   poll_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n && busy && addr == last_addr)
      |=> rd_data[DATA_W-1] == ~$past(last_data[DATA_W-1]));

   // R5
   reserved_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n && busy && addr == last_addr)
      |=> rd_data[DATA_W-3:0] == $past(last_data[DATA_W-3:0]));

   // R4
   toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && $past(!ce_n && !oe_n) && (ce_n || oe_n))
      |=> tog != $past(tog));

   // R6
   toggle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> !tog);

   // R7
   toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(tog));

   // R8
   capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(last_data) && $stable(last_addr)));

   // R10
   read_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n) |=> $stable(last_data));
endmodule

bind poll_status_resp psr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ce_n     (ce_n),
   .oe_n     (oe_n),
   .busy     (busy),
   .addr     (addr),
   .rd_data  (rd_data),
   .rd_oe    (rd_oe),
   .tog      (tog_q),
   .last_addr(last_addr),
   .last_data(last_data)
);

// File: tb/tb_poll_status_resp.sv
module tb_poll_status_resp;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 15;
   localparam int DW = 8;
   localparam int NVEC = 34;

   typedef struct packed {
      logic          ce_n;
      logic          oe_n;
      logic          we_n;
      logic          busy;
      logic [AW-1:0] addr;
      logic [DW-1:0] din;
      logic [DW-1:0] arr;
      logic          eoe;
      logic [DW-1:0] edat;
      logic [23:0]   tag;
   } vec_t;

   // Expected values: status = {~data[7], toggle, data[5:0]}; toggle inverts after each
   // read access that ends while busy stays high, clears when busy rises.
   localparam vec_t VEC [0:NVEC-1] = '{
      '{1'b1,1'b1,1'b1,1'b0,15'h0000,8'h00,8'h00,1'b0,8'h00,"R1 "},
      '{1'b0,1'b1,1'b0,1'b0,15'h1234,8'h35,8'h00,1'b0,8'h00,"R1 "},
      '{1'b1,1'b1,1'b1,1'b0,15'h1234,8'h35,8'h00,1'b0,8'h00,"R1 "},
      '{1'b0,1'b0,1'b1,1'b0,15'h0001,8'h00,8'hA5,1'b1,8'hA5,"R2 "},
      '{1'b1,1'b1,1'b1,1'b1,15'h0000,8'h00,8'h00,1'b0,8'h00,"R1 "},
      '{1'b0,1'b0,1'b1,1'b1,15'h1234,8'h00,8'hFF,1'b1,8'hB5,"R3 "},
      '{1'b1,1'b1,1'b1,1'b1,15'h0000,8'h00,8'h00,1'b0,8'h00,"R1 "},
      '{1'b0,1'b0,1'b1,1'b1,15'h1234,8'h00,8'hFF,1'b1,8'hF5,"R4 "},
      '{1'b1,1'b1,1'b1,1'b1,15'h0000,8'h00,8'h00,1'b0,8'h00,"R1 "},
      '{1'b0,1'b0,1'b1,1'b1,15'h1234,8'h00,8'hFF,1'b1,8'hB5,"R5 "},
      '{1'b0,1'b0,1'b1,1'b1,15'h1234,8'h00,8'hFF,1'b1,8'hB5,"R4 "},
      '{1'b1,1'b1,1'b1,1'b1,15'h0000,8'h00,8'h00,1'b0,8'h00,"R1 "},
      '{1'b0,1'b0,1'b1,1'b1,15'h0002,8'h00,8'h5A,1'b1,8'h5A,"R9 "},
      '{1'b1,1'b1,1'b1,1'b1,15'h0000,8'h00,8'h00,1'b0,8'h00,"R1 "},
      '{1'b0,1'b1,1'b0,1'b1,15'h0777,8'h00,8'h00,1'b0,8'h00,"R8 "},
      '{1'b1,1'b1,1'b1,1'b1,15'h0000,8'h00,8'h00,1'b0,8'h00,"R1 "},
      '{1'b0,1'b0,1'b1,1'b1,15'h1234,8'h00,8'h00,1'b1,8'hB5,"R8 "},
      '{1'b1,1'b1,1'b1,1'b1,15'h0000,8'h00,8'h00,1'b0,8'h00,"R1 "},
      '{1'b1,1'b1,1'b1,1'b0,15'h0000,8'h00,8'h00,1'b0,8'h00,"R7 "},
      '{1'b0,1'b0,1'b1,1'b0,15'h1234,8'h00,8'h35,1'b1,8'h35,"R7 "},
      '{1'b1,1'b1,1'b1,1'b0,15'h0000,8'h00,8'h00,1'b0,8'h00,"R7 "},
      '{1'b1,1'b1,1'b1,1'b1,15'h0000,8'h00,8'h00,1'b0,8'h00,"R6 "},
      '{1'b0,1'b0,1'b1,1'b1,15'h1234,8'h00,8'h00,1'b1,8'hB5,"R6 "},
      '{1'b1,1'b1,1'b1,1'b1,15'h0000,8'h00,8'h00,1'b0,8'h00,"R1 "},
      '{1'b1,1'b1,1'b1,1'b0,15'h0000,8'h00,8'h00,1'b0,8'h00,"R1 "},
      '{1'b0,1'b0,1'b0,1'b0,15'h1234,8'hC0,8'h11,1'b1,8'h11,"R10"},
      '{1'b1,1'b1,1'b1,1'b1,15'h0000,8'h00,8'h00,1'b0,8'h00,"R1 "},
      '{1'b0,1'b0,1'b1,1'b1,15'h1234,8'h00,8'h00,1'b1,8'hB5,"R10"},
      '{1'b1,1'b0,1'b1,1'b1,15'h1234,8'h00,8'h77,1'b0,8'h00,"R1 "},
      '{1'b0,1'b1,1'b1,1'b1,15'h1234,8'h00,8'h77,1'b0,8'h00,"R1 "},
      '{1'b1,1'b1,1'b1,1'b0,15'h0000,8'h00,8'h00,1'b0,8'h00,"R1 "},
      '{1'b0,1'b1,1'b0,1'b0,15'h4000,8'h8C,8'h00,1'b0,8'h00,"R8 "},
      '{1'b1,1'b1,1'b1,1'b1,15'h0000,8'h00,8'h00,1'b0,8'h00,"R6 "},
      '{1'b0,1'b0,1'b1,1'b1,15'h4000,8'h00,8'h00,1'b1,8'h0C,"R3 "}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0, arr_rdata = '0;
   logic [DW-1:0] rd_data;
   logic          rd_oe;
   int            checks = 0;
   int            errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   poll_status_resp dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .busy(busy), .arr_rdata(arr_rdata),
      .rd_data(rd_data), .rd_oe(rd_oe)
   );

   task automatic drive(input logic c, input logic o, input logic w, input logic b,
                        input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [DW-1:0] r);
      ce_n = c; oe_n = o; we_n = w; busy = b; addr = a; din = d; arr_rdata = r;
   endtask

   task automatic check(input string tag, input logic eoe, input logic [DW-1:0] edat);
      checks++;
      if (rd_oe !== eoe || rd_data !== edat) begin
         errors++;
         $display("FAIL %s: actual oe=%0b data=%02h expected oe=%0b data=%02h",
                  tag, rd_oe, rd_data, eoe, edat);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      check("R1 reset", 1'b0, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         drive(VEC[i].ce_n, VEC[i].oe_n, VEC[i].we_n, VEC[i].busy,
               VEC[i].addr, VEC[i].din, VEC[i].arr);
         @(negedge clk);
         check($sformatf("%s row %0d", VEC[i].tag, i), VEC[i].eoe, VEC[i].edat);
      end

      // R6: reset while the toggle register is set (the read above just ended).
      drive(1'b1, 1'b1, 1'b1, 1'b1, '0, '0, '0);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 during reset", 1'b0, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      // Captured byte is zero after reset: status = {1, 0, 000000}.
      drive(1'b0, 1'b0, 1'b1, 1'b1, '0, '0, 8'hEE);
      @(negedge clk);
      check("R6 after reset", 1'b1, 8'h80);
      drive(1'b1, 1'b1, 1'b1, 1'b1, '0, '0, '0);
      @(negedge clk);
      drive(1'b0, 1'b0, 1'b1, 1'b1, '0, '0, 8'hEE);
      @(negedge clk);
      check("R4 toggle resumes", 1'b1, 8'hC0);
      drive(1'b1, 1'b1, 1'b1, 1'b0, '0, '0, '0);
      @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule